// File: doc/BRIEF.md
# SDRAM Bank State Tracker and Command Checker

This block sits beside the command pins of a double-data-rate SDRAM and watches every registered command. It keeps one state machine per bank: idle, row opening, row open, reading, writing, precharging, and reading or writing with auto-precharge. Each bank's state machine has a down-counter that times the transient states. On every enabled clock the block judges whether the command on the bus is allowed for the bank it addresses. A disallowed command is reported and then ignored.

The row-to-column delay, the precharge time and the burst length are parameters. A plain burst holds its state for half the burst length in clock cycles. An auto-precharge burst holds its state for half the burst length plus the precharge time, and then the bank is idle. The block is meant for a memory-controller test environment, or for a watchdog inside a controller that must never issue a command at the wrong time.

Top module: `sdram_bank_guard`

## Requirements
- R1: The strobes {cs_n, ras_n, cas_n, we_n} are decoded as follows: cs_n=1 is deselect, 0111 no-op, 0011 activate, 0101 read, 0100 write, 0010 precharge, 0110 burst stop, 0001 refresh and 0000 mode load. Deselect and no-op are legal in every state and change no bank, while running timers keep counting.
- R2: After reset every bank is idle and cmd_err is low. The state of bank b appears on bank_state[3b+2:3b] with the codes idle 0, opening 1, open 2, reading 3, writing 4, precharging 5, reading with auto-precharge 6 and writing with auto-precharge 7.
- R3: In the idle state, activate is legal. It moves the bank to opening for T_RCD cycles and then to open.
- R4: In the open state, read, write and precharge are legal. A read or write with auto_pre low holds reading or writing for BURST_LEN/2 cycles and then returns the bank to open.
- R5: While reading, a read restarts the burst, a write switches to writing, a precharge cuts the burst short, and a burst stop returns the bank to open on the next cycle.
- R6: While writing, read, write and precharge are legal, with precharge cutting the burst short. Burst stop is illegal.
- R7: A legal precharge moves the bank to precharging for T_RP cycles and then to idle. Precharge to an idle bank is illegal.
- R8: A read or write with auto_pre high enters the matching auto-precharge state for BURST_LEN/2+T_RP cycles and then goes to idle. Only no-op or deselect may address the bank in that state, in the opening state, or in the precharging state.
- R9: Refresh and mode load are legal only when every bank is idle, and they change no bank.
- R10: When a command is illegal, cmd_legal is low in the same cycle and cmd_err is high for exactly the following cycle. The addressed bank takes no transition, but its timer keeps running.
- R11: A command is judged only when cke is high on both the current edge and the previous edge. Otherwise cmd_legal is high, no error is raised, and all states and timers hold.
- R12: A command changes only the bank selected by ba. The other banks keep their own states and timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable from the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| auto_pre | input | 1 | Auto-precharge request bit |
| bank_state | output | 3*NUM_BANKS | Packed state code of each bank |
| cmd_legal | output | 1 | The current command is allowed (combinational) |
| cmd_err | output | 1 | Pulse one cycle after an illegal command |

## Verification
A wrong internal state shows on bank_state in the cycle after the edge that caused it. It also shows, during that same cycle, as a wrong cmd_legal verdict for the next command sent to that bank. A miscounted timer shows as a transition one cycle early or late. The bench therefore checks every bank's code after every edge, and not only at the ends of sequences. Errors in the error path show one cycle after the faulty command, on cmd_err.

// File: rtl/bank_guard_pkg.sv
// Shared types for the bank tracker: decoded commands and bank state codes.
// Assumes the state code values are visible at the top-level ports.
package bank_guard_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR,
        CMD_PRE, CMD_BST, CMD_REF, CMD_LMR
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE     = 3'd0,
        BK_OPENING  = 3'd1,
        BK_OPEN     = 3'd2,
        BK_READ     = 3'd3,
        BK_WRITE    = 3'd4,
        BK_CLOSING  = 3'd5,
        BK_READ_AP  = 3'd6,
        BK_WRITE_AP = 3'd7
    } bank_st_e;

endpackage

// File: rtl/cmd_decode.sv
// Command decoder: maps the four active-low strobes to a command.
// Assumes the strobes are sampled on the same edge as the bank state.
module cmd_decode
    import bank_guard_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Pure truth-table decode of the strobe pattern.
    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b110:  cmd = CMD_BST;
                3'b001:  cmd = CMD_REF;
                default: cmd = CMD_LMR;
            endcase
        end
    end

endmodule

// File: rtl/bank_fsm.sv
// Per-bank state machine with a timer for the transient states.
// Assumes: 'go' is high only for a legal command addressed to this bank;
// 'tick' is high when the clock enable allows progress. T_RCD, T_RP and
// BURST_LEN/2 are all at least 1.
module bank_fsm
    import bank_guard_pkg::*;
#(
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int BURST_LEN = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     go,
    input  cmd_e     cmd,
    input  logic     auto_pre,
    output logic     ok,
    output bank_st_e st
);

    localparam int BURST_CYC = BURST_LEN / 2;
    localparam int AP_CYC    = BURST_CYC + T_RP;
    localparam int MAX_A     = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int MAX_CYC   = (AP_CYC > MAX_A) ? AP_CYC : MAX_A;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    bank_st_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             timed;

    assign st    = st_q;
    assign timed = (st_q != BK_IDLE) && (st_q != BK_OPEN);

    // Legality of a non-NOP command for this bank in its current state.
    always_comb begin
        unique case (st_q)
            BK_IDLE:  ok = (cmd == CMD_ACT);
            BK_OPEN:  ok = (cmd == CMD_RD) || (cmd == CMD_WR) || (cmd == CMD_PRE);
            BK_READ:  ok = (cmd == CMD_RD) || (cmd == CMD_WR) || (cmd == CMD_PRE)
                           || (cmd == CMD_BST);
            BK_WRITE: ok = (cmd == CMD_RD) || (cmd == CMD_WR) || (cmd == CMD_PRE);
            default:  ok = 1'b0;
        endcase
    end

    // Next state and timer: accepted commands win over timer expiry.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (go) begin
            unique case (cmd)
                CMD_ACT: begin
                    st_d  = BK_OPENING;
                    cnt_d = CNT_W'(T_RCD - 1);
                end
                CMD_RD: begin
                    st_d  = auto_pre ? BK_READ_AP : BK_READ;
                    cnt_d = auto_pre ? CNT_W'(AP_CYC - 1) : CNT_W'(BURST_CYC - 1);
                end
                CMD_WR: begin
                    st_d  = auto_pre ? BK_WRITE_AP : BK_WRITE;
                    cnt_d = auto_pre ? CNT_W'(AP_CYC - 1) : CNT_W'(BURST_CYC - 1);
                end
                CMD_PRE: begin
                    st_d  = BK_CLOSING;
                    cnt_d = CNT_W'(T_RP - 1);
                end
                CMD_BST: begin
                    st_d  = BK_OPEN;
                    cnt_d = '0;
                end
                default: ;
            endcase
        end else if (tick && timed) begin
            if (cnt_q == '0) begin
                unique case (st_q)
                    BK_OPENING, BK_READ, BK_WRITE: st_d = BK_OPEN;
                    default:                       st_d = BK_IDLE;
                endcase
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    // State and timer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/sdram_bank_guard.sv
// Top level: decodes the bus, applies the clock-enable gate, routes each
// command to its bank and reports legality. Assumes NUM_BANKS >= 2.
module sdram_bank_guard
    import bank_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int BURST_LEN = 4,
    localparam int BA_W     = $clog2(NUM_BANKS),
    localparam int ST_W     = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cke,
    input  logic                      cs_n,
    input  logic                      ras_n,
    input  logic                      cas_n,
    input  logic                      we_n,
    input  logic [BA_W-1:0]           ba,
    input  logic                      auto_pre,
    output logic [NUM_BANKS*ST_W-1:0] bank_state,
    output logic                      cmd_legal,
    output logic                      cmd_err
);

    cmd_e                 cmd;
    logic                 cke_q;
    logic                 tick;
    logic                 legal_raw;
    logic                 bank_cmd;
    logic [NUM_BANKS-1:0] ok_v;
    logic [NUM_BANKS-1:0] idle_v;
    logic                 err_q;

    cmd_decode u_dec (
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .cmd  (cmd)
    );

    // Remember the clock enable of the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_q <= 1'b0;
        else        cke_q <= cke;
    end

    assign tick     = cke_q && cke;
    assign bank_cmd = (cmd == CMD_ACT) || (cmd == CMD_RD) || (cmd == CMD_WR)
                      || (cmd == CMD_PRE) || (cmd == CMD_BST);

    // Verdict on the bus command: global commands need all banks idle.
    always_comb begin
        unique case (cmd)
            CMD_DESEL, CMD_NOP: legal_raw = 1'b1;
            CMD_REF, CMD_LMR:   legal_raw = &idle_v;
            default:            legal_raw = ok_v[ba];
        endcase
    end

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic     go_b;
            bank_st_e st_b;

            assign go_b = tick && legal_raw && bank_cmd && (ba == BA_W'(b));

            bank_fsm #(
                .T_RCD    (T_RCD),
                .T_RP     (T_RP),
                .BURST_LEN(BURST_LEN)
            ) u_fsm (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick),
                .go      (go_b),
                .cmd     (cmd),
                .auto_pre(auto_pre),
                .ok      (ok_v[b]),
                .st      (st_b)
            );

            assign bank_state[b*ST_W +: ST_W] = st_b;
            assign idle_v[b]                  = (st_b == BK_IDLE);
        end
    endgenerate

    // One-cycle error pulse after an illegal enabled command.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= tick && !legal_raw;
    end

    assign cmd_legal = !tick || legal_raw;
    assign cmd_err   = err_q;

endmodule

// File: rtl/bank_guard_chk.sv
// Property checker for sdram_bank_guard, attached by bind below.
// Decodes the strobes on its own, independently of the design's decoder.
module bank_guard_chk #(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cke,
    input logic                   cke_q,
    input logic                   cs_n,
    input logic                   ras_n,
    input logic                   cas_n,
    input logic                   we_n,
    input logic [BA_W-1:0]        ba,
    input logic [NUM_BANKS*3-1:0] bank_state,
    input logic                   cmd_legal,
    input logic                   cmd_err
);

    logic on;
    logic is_act;
    logic is_pre;

    assign on     = cke_q && cke;
    assign is_act = !cs_n && !ras_n && cas_n && we_n;
    assign is_pre = !cs_n && !ras_n && cas_n && !we_n;

    // R10
    err_after_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on && !cmd_legal) |=> cmd_err);

    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(on && !cmd_legal));

    // R1
    nop_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || (ras_n && cas_n && we_n)) |-> cmd_legal);

    // R11
    cke_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(bank_state) && !cmd_err));

    // R9
    global_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on && !cs_n && !ras_n && !cas_n && cmd_legal) |-> (bank_state == '0));

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
            // R3
            act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (on && is_act && cmd_legal && ba == BA_W'(b))
                |=> bank_state[b*3 +: 3] == 3'd1);

            // R7
            pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (on && is_pre && cmd_legal && ba == BA_W'(b))
                |=> bank_state[b*3 +: 3] == 3'd5);

            // R10
            illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (on && !cmd_legal && ba == BA_W'(b)
                 && (bank_state[b*3 +: 3] == 3'd0 || bank_state[b*3 +: 3] == 3'd2))
                |=> $stable(bank_state[b*3 +: 3]));
        end
    endgenerate

endmodule

bind sdram_bank_guard bank_guard_chk #(
    .NUM_BANKS(NUM_BANKS),
    .BA_W     (BA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cke_q     (cke_q),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .bank_state(bank_state),
    .cmd_legal (cmd_legal),
    .cmd_err   (cmd_err)
);

// File: tb/test_sdram_bank_guard.sv
// Scoreboard bench: the driver pushes one expected item per cycle, and the
// monitor pops each item and compares the verdict before the edge and the
// error and state codes after the edge.
module test_sdram_bank_guard;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [3:0] DES = 4'b1111, NOP = 4'b0111, ACT = 4'b0011,
                           RD  = 4'b0101, WR  = 4'b0100, PRE = 4'b0010,
                           BST = 4'b0110, REF = 4'b0001, LMR = 4'b0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic        auto_pre = 1'b0;
    logic [11:0] bank_state;
    logic        cmd_legal;
    logic        cmd_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          legal;
        logic [11:0] states;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    sdram_bank_guard i_sdram_bank_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke       (cke),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .auto_pre  (auto_pre),
        .bank_state(bank_state),
        .cmd_legal (cmd_legal),
        .cmd_err   (cmd_err)
    );

    function automatic logic [11:0] st4(input logic [2:0] s3, s2, s1, s0);
        return {s3, s2, s1, s0};
    endfunction

    task automatic cmp(input logic [11:0] act, input logic [11:0] exp,
                       input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] p, input logic [1:0] b, input logic a,
                        input logic c, input bit el, input logic [11:0] es,
                        input string tag);
        exp_t e;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = p;
        ba       = b;
        auto_pre = a;
        cke      = c;
        e.legal  = el;
        e.states = es;
        e.tag    = tag;
        sb.push_back(e);
    endtask

    // Monitor: verdict before the edge, error and states after it.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() != 0) begin
                e = sb.pop_front();
                cmp({11'd0, cmd_legal}, {11'd0, e.legal}, e.tag, "cmd_legal");
                @(posedge clk);
                #1;
                cmp({11'd0, cmd_err}, {11'd0, !e.legal}, e.tag, "cmd_err");
                cmp(bank_state, e.states, e.tag, "bank_state");
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #20000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        cmp(bank_state, 12'h000, "R2", "reset bank_state");
        cmp({11'd0, cmd_err}, 12'd0, "R2", "reset cmd_err");
        rst_n = 1'b1;

        step(NOP, 0, 0, 1, 1, st4(0,0,0,0), "R1 nop");
        step(ACT, 0, 0, 1, 1, st4(0,0,0,1), "R3 act");
        step(RD,  0, 0, 1, 0, st4(0,0,0,1), "R10 read while opening");
        step(NOP, 0, 0, 1, 1, st4(0,0,0,2), "R3 open after tRCD");
        step(RD,  0, 0, 1, 1, st4(0,0,0,3), "R4 read");
        step(NOP, 0, 0, 1, 1, st4(0,0,0,3), "R4 burst");
        step(NOP, 0, 0, 1, 1, st4(0,0,0,2), "R4 burst end");
        step(WR,  0, 0, 1, 1, st4(0,0,0,4), "R4 write");
        step(BST, 0, 0, 1, 0, st4(0,0,0,4), "R6 stop in write");
        step(NOP, 0, 0, 1, 1, st4(0,0,0,2), "R4 write end");
        step(RD,  0, 0, 1, 1, st4(0,0,0,3), "R4 read again");
        step(BST, 0, 0, 1, 1, st4(0,0,0,2), "R5 stop in read");
        step(RD,  0, 0, 1, 1, st4(0,0,0,3), "R5 read");
        step(WR,  0, 0, 1, 1, st4(0,0,0,4), "R5 write in read");
        step(PRE, 0, 0, 1, 1, st4(0,0,0,5), "R6 pre truncates write");
        step(DES, 2, 0, 1, 1, st4(0,0,0,5), "R1 deselect");
        step(NOP, 0, 0, 1, 1, st4(0,0,0,0), "R7 idle after tRP");
        step(ACT, 1, 0, 1, 1, st4(0,0,1,0), "R12 act bank1");
        step(REF, 0, 0, 1, 0, st4(0,0,1,0), "R9 refresh not all idle");
        step(NOP, 0, 0, 1, 1, st4(0,0,2,0), "R3 bank1 open");
        step(RD,  1, 1, 1, 1, st4(0,0,6,0), "R8 read auto-pre");
        step(ACT, 0, 0, 1, 1, st4(0,0,6,1), "R12 act other bank");
        step(WR,  1, 0, 1, 0, st4(0,0,6,1), "R8 write in auto-pre");
        step(NOP, 0, 0, 1, 1, st4(0,0,6,2), "R8 auto-pre running");
        step(NOP, 0, 0, 1, 1, st4(0,0,0,2), "R8 auto-pre done");
        step(ACT, 2, 0, 0, 1, st4(0,0,0,2), "R11 cke low");
        step(ACT, 2, 0, 1, 1, st4(0,0,0,2), "R11 cke was low");
        step(ACT, 2, 0, 1, 1, st4(0,1,0,2), "R11 cke back");
        step(NOP, 0, 0, 0, 1, st4(0,1,0,2), "R11 timer frozen");
        step(NOP, 0, 0, 1, 1, st4(0,1,0,2), "R11 timer frozen 2");
        step(NOP, 0, 0, 1, 1, st4(0,1,0,2), "R11 timer resumes");
        step(NOP, 0, 0, 1, 1, st4(0,2,0,2), "R11 open late");
        step(PRE, 0, 0, 1, 1, st4(0,2,0,5), "R7 pre bank0");
        step(PRE, 2, 0, 1, 1, st4(0,5,0,5), "R7 pre bank2");
        step(NOP, 0, 0, 1, 1, st4(0,5,0,0), "R7 bank0 idle");
        step(NOP, 0, 0, 1, 1, st4(0,0,0,0), "R7 bank2 idle");
        step(LMR, 1, 0, 1, 1, st4(0,0,0,0), "R9 mode load");
        step(REF, 3, 0, 1, 1, st4(0,0,0,0), "R9 refresh");
        step(PRE, 3, 0, 1, 0, st4(0,0,0,0), "R7 pre on idle");
        step(ACT, 3, 0, 1, 1, st4(1,0,0,0), "R3 act bank3");
        step(NOP, 0, 0, 1, 1, st4(1,0,0,0), "R3 opening");
        step(NOP, 0, 0, 1, 1, st4(2,0,0,0), "R3 open");
        step(WR,  3, 1, 1, 1, st4(7,0,0,0), "R8 write auto-pre");
        step(RD,  3, 0, 1, 0, st4(7,0,0,0), "R8 read in auto-pre");
        step(NOP, 0, 0, 1, 1, st4(7,0,0,0), "R8 wait");
        step(NOP, 0, 0, 1, 1, st4(7,0,0,0), "R8 wait 2");
        step(NOP, 0, 0, 1, 1, st4(0,0,0,0), "R8 idle");
        step(ACT, 3, 0, 1, 1, st4(1,0,0,0), "R3 reopen");
        step(NOP, 0, 0, 1, 1, st4(1,0,0,0), "R3 opening 2");
        step(NOP, 0, 0, 1, 1, st4(2,0,0,0), "R3 open 2");
        step(RD,  3, 0, 1, 1, st4(3,0,0,0), "R5 read bank3");
        step(PRE, 3, 0, 1, 1, st4(5,0,0,0), "R5 pre truncates read");
        step(NOP, 0, 0, 1, 1, st4(5,0,0,0), "R7 closing");
        step(NOP, 0, 0, 1, 1, st4(0,0,0,0), "R7 closed");
        step(NOP, 0, 0, 1, 1, st4(0,0,0,0), "R1 tail");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule